// File: doc/BRIEF.md
# DDR Serial Word Aligner

This block receives one serial lane from a 14-bit ADC. The lane runs at double data rate and is centre aligned, so each period of the bit clock carries two bits. The bit that is present at the rising edge comes first, and the bit present at the following falling edge comes second. Seven bit-clock periods make up one sample. The block does not use a frame clock from the converter. It counts bit-clock cycles to produce its own frame timing, which stays in phase with the bit clock, and it drives a divide-by-seven frame clock output.

The word boundary is found by searching while the converter sends a known training word. At each frame boundary the block compares the deserialized word with the training value. After a miss it moves the boundary by one bit position and waits for the shifted word to settle. After enough consecutive hits it reports lock. When no slip position gives a match, an error flag is raised and the search continues.

Locked samples leave through a valid/ready port. The converter cannot be stalled, so back-pressure has a limited meaning. A sample stays on the port until it is accepted or until the next frame boundary. At that boundary it is replaced, and an unaccepted sample is lost.

Top module: `ddr_word_aligner`

## Requirements
- R1: During and right after reset, `locked`, `align_err` and `smp_valid` are 0, and `frame_clk` is 1.
- R2: Rising bit-clock edges are numbered from 0, starting with the first edge after reset is released. After edge k, `frame_clk` is 1 exactly when (k+1) mod 7 is less than 4. Its period is therefore 7 bit clocks: high for 4 and low for 3.
- R3: Stream bit 2k is the level of `ser_in` at rising edge k, and bit 2k+1 is its level at the falling edge that follows. Edges p with p mod 7 = 6 are frame boundaries. At boundary p, with slip position s, the captured word holds stream bits 2p-16-s through 2p-3-s. The oldest of these bits is placed in bit 13.
- R4: A boundary is a compare boundary when `train_en` is 1 and no settle wait is pending. If the word at a compare boundary differs from the training word, s advances by one (from 13 it wraps to 0), and the next two boundaries are not compared.
- R5: At the compare boundary that gives the 4th consecutive match, `locked` rises. A mismatch at a compare boundary clears `locked`. `locked` changes only at boundaries.
- R6: Slips are counted from reset or from the last lock. When this count reaches 14, `align_err` is set and the count restarts; the search goes on from the wrapped slip position. `align_err` is cleared when lock is reached, so it is never 1 together with `locked`.
- R7: When `train_en` is 0 at a boundary, that boundary makes no compare, changes neither the slip position nor `locked`, and advances no settle wait.
- R8: `smp_valid` rises only at a boundary where `locked` is 1 after the update, and `smp_data` then carries that boundary's word. The sample stays unchanged until it is accepted by `smp_ready`=1 at an edge, or until the next boundary replaces it.
- R9: At a boundary where `locked` is 0 after the update, `smp_valid` is cleared, so no sample is offered while the block is unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock; data is captured on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial DDR lane |
| train_en | input | 1 | 1 while the converter sends the training word; 0 holds the alignment |
| frame_clk | output | 1 | Local divide-by-7 frame clock |
| smp_data | output | 14 | Aligned sample, first received bit in bit 13 |
| smp_valid | output | 1 | Sample on `smp_data` is valid |
| smp_ready | input | 1 | Consumer takes the sample at the edge where it is 1 together with `smp_valid` |
| locked | output | 1 | Word boundary found |
| align_err | output | 1 | A full round of slip positions passed without lock |

## Verification
Two events can fall on the same edge: arrival of a new sample at a frame boundary, and a pending sample that has not been accepted yet or is being accepted on that same edge. The bench holds `smp_ready` low for runs of nine cycles, longer than one frame, and then high again. This forces boundaries to land during stall periods and during acceptance periods. A behavioural model tracks the one-slot port and checks on every cycle that the new word replaces the old one and that `smp_valid` stays high.

// File: rtl/dal_pkg.sv
package dal_pkg;

  // Alignment status carried from the search unit to the top
  typedef struct packed {
    logic locked;
    logic err;
  } dal_status_t;

  // Frame clock high phases out of a frame of cyc bit clocks
  function automatic int unsigned dal_hi_phases(int unsigned cyc);
    return (cyc + 1) / 2;
  endfunction

endpackage

// File: rtl/dal_ddr_capture.sv
module dal_ddr_capture #(
  parameter int unsigned W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  output logic [2*W-1:0]  hist
);
  localparam int unsigned HW = 2 * W;

  logic rise_q;
  logic fall_q;

  // Falling-edge half of the DDR capture
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= din;
  end

  // Rising-edge half, then append the completed pair (rise bit first)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      hist   <= '0;
    end else begin
      rise_q <= din;
      hist   <= {hist[HW-3:0], rise_q, fall_q};
    end
  end
endmodule

// File: rtl/dal_frame_timer.sv
module dal_frame_timer #(
  parameter int unsigned CYC = 7
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe,
  output logic frame_clk
);
  localparam int unsigned PW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC - 1);
  localparam logic [PW-1:0] HI   = PW'(dal_pkg::dal_hi_phases(CYC));

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_n;

  assign strobe = (ph_q == LAST);
  assign ph_n   = strobe ? '0 : ph_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= '0;
      frame_clk <= 1'b1;
    end else begin
      ph_q      <= ph_n;
      frame_clk <= (ph_n < HI);
    end
  end
endmodule

// File: rtl/dal_window.sv
module dal_window #(
  parameter int unsigned     W     = 14,
  parameter logic [W-1:0]    TRAIN = 14'b11111110000000
) (
  input  logic [2*W-1:0]          hist,
  input  logic [$clog2(W)-1:0]    slip,
  output logic [W-1:0]            word,
  output logic                    match
);
  // Larger slip looks further back in time by one bit per step
  always_comb begin
    word  = hist[slip +: W];
    match = (word == TRAIN);
  end
endmodule

// File: rtl/dal_slip_search.sv
module dal_slip_search #(
  parameter int unsigned W      = 14,
  parameter int unsigned LOCK_N = 4,
  parameter int unsigned SETTLE = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strobe,
  input  logic                    train_en,
  input  logic                    match,
  output logic [$clog2(W)-1:0]    slip,
  output dal_pkg::dal_status_t    stat,
  output logic                    lock_nxt
);
  localparam int unsigned SLW = $clog2(W);
  localparam int unsigned STW = $clog2(W + 1);
  localparam int unsigned MW  = $clog2(LOCK_N + 1);
  localparam int unsigned WW  = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1;

  localparam logic [SLW-1:0] SLIP_LAST = SLW'(W - 1);
  localparam logic [STW-1:0] STEP_LAST = STW'(W - 1);
  localparam logic [MW-1:0]  M_LAST    = MW'(LOCK_N - 1);
  localparam logic [WW-1:0]  SETTLE_V  = WW'(SETTLE);

  logic [SLW-1:0] slip_q, slip_n;
  logic [STW-1:0] step_q, step_n;
  logic [MW-1:0]  mcnt_q, mcnt_n;
  logic [WW-1:0]  wait_q, wait_n;
  logic           lock_q, lock_n;
  logic           err_q,  err_n;

  always_comb begin
    slip_n = slip_q;
    step_n = step_q;
    mcnt_n = mcnt_q;
    wait_n = wait_q;
    lock_n = lock_q;
    err_n  = err_q;
    if (strobe && train_en) begin
      if (wait_q != '0) begin
        wait_n = wait_q - 1'b1;
      end else if (match) begin
        if (mcnt_q >= M_LAST) begin
          lock_n = 1'b1;
          err_n  = 1'b0;
          step_n = '0;
        end else begin
          mcnt_n = mcnt_q + 1'b1;
        end
      end else begin
        mcnt_n = '0;
        lock_n = 1'b0;
        wait_n = SETTLE_V;
        slip_n = (slip_q == SLIP_LAST) ? '0 : slip_q + 1'b1;
        if (step_q == STEP_LAST) begin
          step_n = '0;
          err_n  = 1'b1;
        end else begin
          step_n = step_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slip_q <= '0;
      step_q <= '0;
      mcnt_q <= '0;
      wait_q <= '0;
      lock_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      slip_q <= slip_n;
      step_q <= step_n;
      mcnt_q <= mcnt_n;
      wait_q <= wait_n;
      lock_q <= lock_n;
      err_q  <= err_n;
    end
  end

  assign slip        = slip_q;
  assign stat.locked = lock_q;
  assign stat.err    = err_q;
  assign lock_nxt    = lock_n;
endmodule

// File: rtl/dal_out_stage.sv
module dal_out_stage #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic         lock_nxt,
  input  logic [W-1:0] word,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  // One slot; a frame boundary overwrites whatever is pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (strobe) begin
      valid <= lock_nxt;
      if (lock_nxt) data <= word;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr_word_aligner.sv
module ddr_word_aligner #(
  parameter int unsigned  W      = 14,
  parameter logic [W-1:0] TRAIN  = 14'b11111110000000,
  parameter int unsigned  LOCK_N = 4,
  parameter int unsigned  SETTLE = 2
) (
  input  logic         clk_bit,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         train_en,
  output logic         frame_clk,
  output logic [W-1:0] smp_data,
  output logic         smp_valid,
  input  logic         smp_ready,
  output logic         locked,
  output logic         align_err
);
  // W must be even: two bits per bit-clock period
  localparam int unsigned CYC = W / 2;
  localparam int unsigned SLW = $clog2(W);

  logic [2*W-1:0]       hist;
  logic                 strobe;
  logic [SLW-1:0]       slip;
  logic [W-1:0]         word;
  logic                 match;
  logic                 lock_nxt;
  dal_pkg::dal_status_t stat;

  dal_ddr_capture #(.W(W)) u_cap (
    .clk  (clk_bit),
    .rst_n(rst_n),
    .din  (ser_in),
    .hist (hist)
  );

  dal_frame_timer #(.CYC(CYC)) u_tmr (
    .clk      (clk_bit),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .frame_clk(frame_clk)
  );

  dal_window #(.W(W), .TRAIN(TRAIN)) u_win (
    .hist (hist),
    .slip (slip),
    .word (word),
    .match(match)
  );

  dal_slip_search #(.W(W), .LOCK_N(LOCK_N), .SETTLE(SETTLE)) u_srch (
    .clk     (clk_bit),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .train_en(train_en),
    .match   (match),
    .slip    (slip),
    .stat    (stat),
    .lock_nxt(lock_nxt)
  );

  dal_out_stage #(.W(W)) u_out (
    .clk     (clk_bit),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .lock_nxt(lock_nxt),
    .word    (word),
    .ready   (smp_ready),
    .valid   (smp_valid),
    .data    (smp_data)
  );

  assign locked    = stat.locked;
  assign align_err = stat.err;
endmodule

// File: rtl/dal_checker.sv
module dal_checker #(
  parameter int unsigned W   = 14,
  parameter int unsigned CYC = 7
) (
  input logic         clk_bit,
  input logic         rst_n,
  input logic         train_en,
  input logic         frame_clk,
  input logic         smp_ready,
  input logic         smp_valid,
  input logic [W-1:0] smp_data,
  input logic         locked,
  input logic         align_err
);
  logic       fclk_d;
  logic       seen;
  logic [7:0] since;
  logic       fr_rise;

  assign fr_rise = frame_clk && !fclk_d;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      fclk_d <= 1'b1;
      seen   <= 1'b0;
      since  <= '0;
    end else begin
      fclk_d <= frame_clk;
      if (fr_rise) begin
        seen  <= 1'b1;
        since <= '0;
      end else begin
        since <= since + 1'b1;
      end
    end
  end

  // R2: frame clock rises every CYC bit clocks
  p_frame_period_r2: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (fr_rise && seen) |-> (since == 8'(CYC - 1)));

  // R5: lock changes only at a frame boundary
  p_lock_edge_r5: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !$stable(locked) |-> $rose(frame_clk));

  // R6: error and lock never together
  p_err_excl_r6: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !(locked && align_err));

  // R7: lock only moves when training was on at that edge
  p_freeze_r7: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !$stable(locked) |-> $past(train_en));

  // R8: a stalled sample stays put until the next boundary
  p_hold_r8: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> ($rose(frame_clk) || (smp_valid && $stable(smp_data))));

  // R8: valid appears only at a boundary
  p_valid_rise_r8: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $rose(smp_valid) |-> $rose(frame_clk));

  // R9: no sample offered while unlocked
  p_valid_lock_r9: assert property (@(posedge clk_bit) disable iff (!rst_n)
    smp_valid |-> locked);
endmodule

bind ddr_word_aligner dal_checker #(.W(W), .CYC(W / 2)) u_chk (
  .clk_bit  (clk_bit),
  .rst_n    (rst_n),
  .train_en (train_en),
  .frame_clk(frame_clk),
  .smp_ready(smp_ready),
  .smp_valid(smp_valid),
  .smp_data (smp_data),
  .locked   (locked),
  .align_err(align_err)
);

// File: tb/sim_ddr_word_aligner.sv
module sim_ddr_word_aligner;
  localparam int W  = 14;
  localparam int NB = 8000;
  localparam logic [13:0] TRAIN = 14'b11111110000000;

  logic clk_bit = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0;
  logic train_en = 1'b0;
  logic smp_ready = 1'b0;
  logic frame_clk;
  logic [13:0] smp_data;
  logic smp_valid;
  logic locked;
  logic align_err;

  ddr_word_aligner #(.W(W), .TRAIN(TRAIN), .LOCK_N(4), .SETTLE(2)) u0 (
    .clk_bit(clk_bit), .rst_n(rst_n), .ser_in(ser_in), .train_en(train_en),
    .frame_clk(frame_clk), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .locked(locked), .align_err(align_err)
  );

  always #10 clk_bit = ~clk_bit;

  bit sb [NB];
  int vec = 0;
  int bad = 0;
  int k = 0;
  int mode = 0;
  int toff = 0;
  bit done = 0;

  // behavioural reference state
  int m_slip = 0, m_wait = 0, m_steps = 0, m_mcnt = 0;
  bit m_lock = 0, m_err = 0, m_valid = 0;
  logic [13:0] m_data = '0;

  function automatic logic [13:0] dword(int n);
    return 14'((n * 291 + 85) ^ (n * 37));
  endfunction

  function automatic bit getb(int i);
    if (i < 0 || i >= NB) return 1'b0;
    return sb[i];
  endfunction

  // R3: word at boundary p, slip s = bits 2p-16-s .. 2p-3-s, oldest in bit 13
  function automatic logic [13:0] mword(int p, int s);
    logic [13:0] w;
    for (int j = 0; j < 14; j++) w[13-j] = getb(2*p - 16 - s + j);
    return w;
  endfunction

  task automatic drive_bit(int idx);
    bit b;
    logic [13:0] t;
    case (mode)
      1: b = TRAIN[13 - ((idx + toff) % 14)];
      2: begin t = dword((idx + toff) / 14); b = t[13 - ((idx + toff) % 14)]; end
      default: b = 1'b0;
    endcase
    if (idx < NB) sb[idx] = b;
    ser_in = b;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (edge %0d)", tag, what, act, exp, k);
    end
  endtask

  task automatic model_edge(bit tr, bit rd);
    logic [13:0] w;
    if (k % 7 == 6) begin
      w = mword(k, m_slip);
      if (tr) begin
        if (m_wait > 0) m_wait--;
        else if (w == TRAIN) begin
          m_mcnt++;
          if (m_mcnt >= 4) begin m_lock = 1; m_err = 0; m_steps = 0; end
        end else begin
          m_mcnt = 0; m_lock = 0; m_wait = 2;
          m_slip = (m_slip + 1) % 14;
          m_steps++;
          if (m_steps == 14) begin m_err = 1; m_steps = 0; end
        end
      end
      if (m_lock) begin m_valid = 1; m_data = w; end
      else m_valid = 0;
    end else if (m_valid && rd) begin
      m_valid = 0;
    end
  endtask

  task automatic step();
    bit tr, rd;
    @(posedge clk_bit);
    tr = train_en;
    rd = smp_ready;
    model_edge(tr, rd);
    #3;
    chk("R2", "frame_clk", int'(frame_clk), int'(((k + 1) % 7) < 4));
    chk("R5", "locked", int'(locked), int'(m_lock));
    chk("R6", "align_err", int'(align_err), int'(m_err));
    chk("R8", "smp_valid", int'(smp_valid), int'(m_valid));
    if (m_valid) chk("R3", "smp_data", int'(smp_data), int'(m_data));
    #2;
    drive_bit(2*k + 1);
    @(negedge clk_bit);
    #5;
    drive_bit(2*k + 2);
    k++;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_bit);
    #5;
    rst_n = 1'b1;
    mode = 0;
    drive_bit(0);
    #1;
    chk("R1", "reset locked", int'(locked), 0);
    chk("R1", "reset align_err", int'(align_err), 0);
    chk("R1", "reset smp_valid", int'(smp_valid), 0);
    chk("R1", "reset frame_clk", int'(frame_clk), 1);

    // training stream whose boundary needs slip 5
    mode = 1; toff = 9; train_en = 1; smp_ready = 1;
    for (int i = 0; i < 200; i++) step();
    chk("R5", "lock after training", int'(locked), 1);
    // R4: slip search converged on the training word
    chk("R4", "aligned word", int'(smp_data), int'(TRAIN));

    // R7 and R8: training off, live data, stalls longer than a frame
    mode = 2; train_en = 0;
    for (int i = 0; i < 160; i++) begin
      smp_ready = ((i / 9) % 3) != 0;
      step();
    end
    chk("R7", "lock held with training off", int'(locked), 1);

    // mismatch in training mode drops lock
    train_en = 1; smp_ready = 1;
    for (int i = 0; i < 30; i++) step();
    chk("R5", "lock lost on mismatch", int'(locked), 0);
    chk("R9", "no valid while unlocked", int'(smp_valid), 0);

    // no slip position matches: error
    mode = 0;
    for (int i = 0; i < 350; i++) step();
    chk("R6", "error after full slip round", int'(align_err), 1);

    // training pattern present but training off: no search
    mode = 1; toff = 3; train_en = 0;
    for (int i = 0; i < 100; i++) step();
    chk("R7", "no lock with training off", int'(locked), 0);

    // search resumes and locks at slip 13, error clears
    train_en = 1;
    for (int i = 0; i < 450; i++) begin
      smp_ready = (i % 4) != 0;
      step();
    end
    chk("R6", "lock after error", int'(locked), 1);
    chk("R6", "error cleared by lock", int'(align_err), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule